// File: doc/BRIEF.md
# Cyclic Sense Wake-Up Timer

This block times the low-power phases of a system supervisor. When the supervisor is in a low-power mode, the block does one of two things with a high-side switch drive. It either holds the drive off for the whole stay, or it pulses the drive on for a short window once in every period. At the last clock of each on-window the block samples a group of wake-up inputs. If any sampled level differs from the level taken at the previous sample point, and sensing is enabled, the block reports an input wake.

A forced wake-up can also be enabled. It fires when the selected period has fully elapsed in low-power mode. A single 3-bit period select sets both the pulse period and the forced wake-up delay. The select is captured while the supervisor is awake and is frozen for the rest of the low-power stay.

When the supervisor is awake, the switch drive follows a normal-mode control input and the counters stay cleared. The wake flag and its cause code stay set until low-power mode is left. Period lengths are computed from a clock-frequency parameter, and the on-window length is a separate cycle-count parameter.

Top module: `cyclic_wake_timer`

## Requirements
- R1: Period select code s (000 to 111) gives a period of CLK_KHZ*T/1000 clock cycles. T is, in microseconds, 4600, 9250, 18500, 37000, 74000, 95500, 191000 and 388000 for codes 0 to 7 in turn.
- R2: With forced wake-up enabled in low-power mode, wake_flag rises exactly one period after low-power entry, with wake_cause = 2'b10.
- R3: In low-power mode with cyclic operation enabled, hs_drv is high for the first ON_CYC cycles of every period. With cyclic operation disabled, hs_drv stays low.
- R4: Outside low-power mode, hs_drv equals hs_norm and the period counter is held at zero, so each low-power entry starts a fresh period with the switch on.
- R5: The wake inputs are sampled in the last cycle of the on-window. A sampled value that differs from the reference (the value stored at the previous sample point, or the value present just before entry) sets wake_flag with wake_cause = 2'b01 in the following cycle. An unchanged input sets nothing.
- R6: With sense_en low, no input wake is taken, whatever the inputs do.
- R7: Once set, wake_flag and the first wake_cause hold through later events while low-power mode lasts. Both clear in the cycle after lp_mode goes low.
- R8: The period select is captured only while lp_mode is low. A change during low-power mode does not alter the period. The captured select resets to 000.
- R9: If lp_mode goes low in the very cycle in which the forced wake-up interval expires, no wake is recorded.
- R10: After reset, wake_flag is low and wake_cause is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lp_mode | input | 1 | High while the supervisor is in a low-power mode |
| period_sel | input | 3 | Period / forced wake-up interval select |
| cyc_en | input | 1 | Pulse the switch periodically in low-power mode (low: keep it off) |
| fwu_en | input | 1 | Enable the forced wake-up at period expiry |
| sense_en | input | 1 | Enable input wake from the sample point |
| hs_norm | input | 1 | Switch drive level used outside low-power mode |
| wk_in | input | N_WK | Wake-up input levels |
| hs_drv | output | 1 | High-side switch drive |
| wake_flag | output | 1 | Wake event flag, sticky during low-power mode |
| wake_cause | output | 2 | 01 input wake, 10 forced wake, 00 none |

## Verification
Two things can fall in the same clock. One is the forced-wake expiry, in the final cycle of a period. The other is the exit from low-power mode, which clears the wake state. The bench enables forced wake-up with the switch cycling off, counts to the last cycle of the first period, and drops lp_mode in exactly that cycle. It then requires the wake flag to stay low on the next edge and after it, because the exit must win over the expiry. A second overlap is a forced expiry that arrives while an input wake is already recorded. There the bench requires the input cause to survive.

// File: rtl/cwt_pkg.sv
package cwt_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_INPUT  = 2'b01,
    CAUSE_FORCED = 2'b10
  } wake_cause_e;

  // interval length in hundredths of a millisecond for each select code
  function automatic int unsigned interval_cms(input logic [2:0] sel);
    case (sel)
      3'd0:    return 460;
      3'd1:    return 925;
      3'd2:    return 1850;
      3'd3:    return 3700;
      3'd4:    return 7400;
      3'd5:    return 9550;
      3'd6:    return 19100;
      default: return 38800;
    endcase
  endfunction

  // period in clock cycles for a given clock frequency in kHz
  function automatic int unsigned period_cycles(input logic [2:0] sel,
                                                input int unsigned clk_khz);
    int unsigned cyc;
    cyc = (clk_khz * interval_cms(sel)) / 100;
    if (cyc < 2) cyc = 2;
    return cyc;
  endfunction

endpackage

// File: rtl/cwt_period_ctr.sv
module cwt_period_ctr #(
  parameter int unsigned CLK_KHZ = 1000,
  parameter int unsigned CNT_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_mode,
  input  logic [2:0]       period_sel,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] period_len,
  output logic             expire
);
  import cwt_pkg::*;

  localparam int unsigned N_CODES = 8;

  logic [2:0]       sel_q;
  logic [CNT_W-1:0] len_tab [N_CODES];

  for (genvar g = 0; g < N_CODES; g++) begin : g_len
    assign len_tab[g] = CNT_W'(period_cycles(3'(g), CLK_KHZ));
  end

  // select is captured only while awake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_q <= 3'd0;
    else if (!lp_mode) sel_q <= period_sel;
  end

  assign period_len = len_tab[sel_q];
  assign expire     = lp_mode && (cnt_q == period_len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!lp_mode) cnt_q <= '0;
    else if (expire)   cnt_q <= '0;
    else               cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/cwt_window.sv
module cwt_window #(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned ON_CYC = 10
) (
  input  logic             lp_mode,
  input  logic             cyc_en,
  input  logic             hs_norm,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             hs_drv,
  output logic             sample_stb
);
  localparam logic [CNT_W-1:0] ON_LEN  = CNT_W'(ON_CYC);
  localparam logic [CNT_W-1:0] ON_LAST = CNT_W'(ON_CYC - 1);

  logic in_win;

  assign in_win     = cnt_q < ON_LEN;
  assign hs_drv     = lp_mode ? (cyc_en && in_win) : hs_norm;
  assign sample_stb = lp_mode && cyc_en && (cnt_q == ON_LAST);

endmodule

// File: rtl/cwt_wake_dec.sv
module cwt_wake_dec #(
  parameter int unsigned N_WK = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lp_mode,
  input  logic            sense_en,
  input  logic            fwu_en,
  input  logic            sample_stb,
  input  logic            expire,
  input  logic [N_WK-1:0] wk_in,
  output logic            in_evt,
  output logic            frc_evt,
  output logic            wake_flag,
  output logic [1:0]      wake_cause
);
  import cwt_pkg::*;

  logic [N_WK-1:0] ref_q;
  wake_cause_e     cause_q;

  // reference level: tracks inputs while awake, refreshed at each sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ref_q <= '0;
    else if (!lp_mode || sample_stb) ref_q <= wk_in;
  end

  assign in_evt  = lp_mode && sense_en && sample_stb && (wk_in != ref_q);
  assign frc_evt = lp_mode && fwu_en && expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_flag <= 1'b0;
      cause_q   <= CAUSE_NONE;
    end else if (!lp_mode) begin
      wake_flag <= 1'b0;
      cause_q   <= CAUSE_NONE;
    end else if (!wake_flag && (in_evt || frc_evt)) begin
      wake_flag <= 1'b1;
      cause_q   <= in_evt ? CAUSE_INPUT : CAUSE_FORCED;
    end
  end

  assign wake_cause = cause_q;

endmodule

// File: rtl/cyclic_wake_timer.sv
module cyclic_wake_timer #(
  parameter int unsigned CLK_KHZ = 1000,
  parameter int unsigned ON_CYC  = (CLK_KHZ * 10 + 999) / 1000,
  parameter int unsigned N_WK    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lp_mode,
  input  logic [2:0]      period_sel,
  input  logic            cyc_en,
  input  logic            fwu_en,
  input  logic            sense_en,
  input  logic            hs_norm,
  input  logic [N_WK-1:0] wk_in,
  output logic            hs_drv,
  output logic            wake_flag,
  output logic [1:0]      wake_cause
);
  import cwt_pkg::*;

  localparam int unsigned MAX_P = period_cycles(3'd7, CLK_KHZ);
  localparam int unsigned CNT_W = $clog2(MAX_P + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period_len;
  logic             expire;
  logic             sample_stb;
  logic             in_evt;
  logic             frc_evt;

  cwt_period_ctr #(.CLK_KHZ(CLK_KHZ), .CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .lp_mode    (lp_mode),
    .period_sel (period_sel),
    .cnt_q      (cnt_q),
    .period_len (period_len),
    .expire     (expire)
  );

  cwt_window #(.CNT_W(CNT_W), .ON_CYC(ON_CYC)) u_win (
    .lp_mode    (lp_mode),
    .cyc_en     (cyc_en),
    .hs_norm    (hs_norm),
    .cnt_q      (cnt_q),
    .hs_drv     (hs_drv),
    .sample_stb (sample_stb)
  );

  cwt_wake_dec #(.N_WK(N_WK)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .lp_mode    (lp_mode),
    .sense_en   (sense_en),
    .fwu_en     (fwu_en),
    .sample_stb (sample_stb),
    .expire     (expire),
    .wk_in      (wk_in),
    .in_evt     (in_evt),
    .frc_evt    (frc_evt),
    .wake_flag  (wake_flag),
    .wake_cause (wake_cause)
  );

endmodule

// File: rtl/cwt_checker.sv
module cwt_checker #(
  parameter int unsigned CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lp_mode,
  input logic             cyc_en,
  input logic             fwu_en,
  input logic             sense_en,
  input logic             hs_drv,
  input logic             wake_flag,
  input logic [1:0]       wake_cause,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] period_len,
  input logic             sample_stb,
  input logic             in_evt
);

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < period_len); // R1

  AST_CNT_HELD_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_mode |=> cnt_q == '0); // R4

  AST_HS_OFF_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode && !cyc_en) |-> !hs_drv); // R3

  AST_SAMPLE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> hs_drv); // R5

  AST_SAMPLE_ENDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && lp_mode) |=> (!hs_drv || !lp_mode)); // R5

  AST_NO_SENSE_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !sense_en |-> !in_evt); // R6

  AST_QUIET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode && !sense_en && !fwu_en && !wake_flag) |=> !wake_flag); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_flag && lp_mode) |=> wake_flag); // R7

  AST_CAUSE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_flag && lp_mode) |=> $stable(wake_cause)); // R7

  AST_CLEAR_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_mode |=> (!wake_flag && wake_cause == 2'b00)); // R9

  AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake_cause) && (wake_flag == (wake_cause != 2'b00))); // R10

endmodule

bind cyclic_wake_timer cwt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lp_mode    (lp_mode),
  .cyc_en     (cyc_en),
  .fwu_en     (fwu_en),
  .sense_en   (sense_en),
  .hs_drv     (hs_drv),
  .wake_flag  (wake_flag),
  .wake_cause (wake_cause),
  .cnt_q      (cnt_q),
  .period_len (period_len),
  .sample_stb (sample_stb),
  .in_evt     (in_evt)
);

// File: tb/test_cyclic_wake_timer.sv
module test_cyclic_wake_timer;

  localparam int unsigned KHZ  = 20;  // scaled frequency so all periods fit
  localparam int unsigned ON   = 4;
  localparam int unsigned NWK  = 4;
  localparam int unsigned P0   = 92;  // code 000 period at KHZ

  // per-code interval in microseconds, index = select code
  localparam int unsigned VEC_US [8] =
    '{4600, 9250, 18500, 37000, 74000, 95500, 191000, 388000};

  logic           clk = 1'b0;
  logic           rst_n;
  logic           lp_mode;
  logic [2:0]     period_sel;
  logic           cyc_en, fwu_en, sense_en, hs_norm;
  logic [NWK-1:0] wk_in;
  logic           hs_drv, wake_flag;
  logic [1:0]     wake_cause;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;  // 125 MHz

  cyclic_wake_timer #(.CLK_KHZ(KHZ), .ON_CYC(ON), .N_WK(NWK)) i_cyclic_wake_timer (
    .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode), .period_sel(period_sel),
    .cyc_en(cyc_en), .fwu_en(fwu_en), .sense_en(sense_en), .hs_norm(hs_norm),
    .wk_in(wk_in), .hs_drv(hs_drv), .wake_flag(wake_flag), .wake_cause(wake_cause)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // leave low power, load settings, then enter low power; returns at sample n=0
  task automatic enter_lp(input logic [2:0] s, input logic c, input logic f, input logic e);
    lp_mode = 1'b0; period_sel = s; cyc_en = c; fwu_en = f; sense_en = e;
    step(2);
    lp_mode = 1'b1;
    #1;
  endtask

  // from sample n=0: first n where hs rises again, and high samples before it
  task automatic measure(output int rise_n, output int hi_cnt, input int limit);
    logic prev;
    rise_n = 0;
    prev   = hs_drv;
    hi_cnt = hs_drv ? 1 : 0;
    for (int n = 1; n <= limit && rise_n == 0; n++) begin
      step();
      if (hs_drv && !prev) rise_n = n;
      else if (hs_drv) hi_cnt++;
      prev = hs_drv;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rise, hi, exp_p;
    rst_n = 1'b0; lp_mode = 1'b0; period_sel = 3'd0; cyc_en = 1'b0;
    fwu_en = 1'b0; sense_en = 1'b0; hs_norm = 1'b0; wk_in = '0;
    step(3);
    // R10 reset state
    check("R10 flag", wake_flag, 0);
    check("R10 cause", wake_cause, 0);
    check("R4 hs follows normal low", hs_drv, 0);
    rst_n = 1'b1;
    step();
    hs_norm = 1'b1; #1;
    check("R4 hs follows normal high", hs_drv, 1);
    hs_norm = 1'b0;

    // R1 R3 period and on-window per code
    for (int k = 0; k < 8; k++) begin
      exp_p = int'((longint'(VEC_US[k]) * KHZ) / 1000);
      enter_lp(3'(k), 1'b1, 1'b0, 1'b0);
      measure(rise, hi, exp_p + 10);
      check($sformatf("R1 period code %0d", k), rise, exp_p);
      check($sformatf("R3 on width code %0d", k), hi, ON);
    end

    // R3 cyclic disabled keeps switch off
    enter_lp(3'd2, 1'b0, 1'b0, 1'b0);
    hi = 0;
    for (int n = 0; n < 400; n++) begin if (hs_drv) hi++; step(); end
    check("R3 hs off when cyclic disabled", hi, 0);

    // R2 forced wake after one period
    enter_lp(3'd0, 1'b0, 1'b1, 1'b0);
    step(P0 - 1);
    check("R2 no flag before expiry", wake_flag, 0);
    step();
    check("R2 flag at expiry", wake_flag, 1);
    check("R2 forced cause", wake_cause, 2);

    // R5 input wake at sample point
    wk_in = '0;
    enter_lp(3'd0, 1'b1, 1'b0, 1'b1);
    wk_in = 4'b0001;
    step(ON - 1);
    check("R5 no flag before sample", wake_flag, 0);
    step();
    check("R5 flag after sample", wake_flag, 1);
    check("R5 input cause", wake_cause, 1);
    // R7 later forced expiry keeps input cause
    fwu_en = 1'b1;
    step(P0 + 2);
    check("R7 flag held", wake_flag, 1);
    check("R7 first cause kept", wake_cause, 1);
    lp_mode = 1'b0;
    step();
    check("R7 flag cleared on exit", wake_flag, 0);
    check("R7 cause cleared on exit", wake_cause, 0);

    // R5 unchanged input gives no wake
    wk_in = 4'b1010;
    enter_lp(3'd0, 1'b1, 1'b0, 1'b1);
    step(2 * P0 + 2);
    check("R5 no wake on unchanged input", wake_flag, 0);

    // R6 sensing disabled
    wk_in = '0;
    enter_lp(3'd0, 1'b1, 1'b0, 1'b0);
    wk_in = 4'b1111;
    step(2 * P0 + 2);
    check("R6 no wake with sense off", wake_flag, 0);
    wk_in = '0;

    // R9 exit coincides with expiry
    enter_lp(3'd0, 1'b0, 1'b1, 1'b0);
    step(P0 - 1);
    lp_mode = 1'b0;
    step();
    check("R9 no wake at exit edge", wake_flag, 0);
    step();
    check("R9 still no wake", wake_flag, 0);

    // R8 select change during low power ignored
    enter_lp(3'd0, 1'b1, 1'b0, 1'b0);
    period_sel = 3'd7;
    measure(rise, hi, P0 + 10);
    check("R8 select frozen in low power", rise, P0);

    // R8 captured select resets to 000
    lp_mode = 1'b1; period_sel = 3'd5; cyc_en = 1'b1;
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    #1;
    measure(rise, hi, P0 + 10);
    check("R8 select reset to code 0", rise, P0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule